// File: doc/BRIEF.md
# USB Transmit Endpoint Packet Controller

This block manages one transmit endpoint of a USB function or host controller. It does not store the payload bytes. It counts the bytes that software or DMA pushes into the endpoint buffer. It holds the packet-ready flag that hands the queued packet to the link layer, and it keeps the DATA0/DATA1 toggle. It also raises a DMA request line whenever the buffer can take more data under the selected request mode.

A processor writes a control byte and a maximum packet size. It pulses a load strobe once per byte and may raise packet-ready by hand. The link side reports each completed transmission attempt with a done strobe and an acknowledge qualifier. An acknowledged packet is removed from the buffer and flips the toggle. A rejected or timed-out packet is kept for retry. Software can also force a toggle flip, which discards the queued packet.

Top module: `usb_tx_ep_ctrl`

## Requirements
- R1: After reset the control byte reads 0, the buffer count is 0, and packet-ready, toggle, overrun, DMA request and order-error outputs are all 0.
- R2: The control byte is laid out as follows. Bit 7 is auto-ready. Bit 6 is isochronous. Bit 5 is direction (1 = transmit). Bit 4 is DMA enable. Bit 3 is force-toggle, a write-1 action that always reads 0. Bit 2 is DMA request mode. Bits 1:0 read 0. A write takes effect on the next clock.
- R3: With auto-ready at 1, the load that brings the byte count to exactly the programmed maximum packet size sets packet-ready on the next clock.
- R4: With auto-ready at 0, or with fewer bytes than the maximum, packet-ready rises only one clock after a `cpu_set_ready` pulse.
- R5: The isochronous bit reads back, and drives `iso_active`, only while `host_mode` is 0. In host mode both read 0.
- R6: With a shared buffer (`SHARED_FIFO`=1) and direction 0, the endpoint is not transmitting. `dma_req` stays 0 and link completions are ignored.
- R7: A control write with bit 3 set flips the toggle and clears the count, packet-ready and overrun on the next clock. It does so whether or not the packet was acknowledged.
- R8: A link completion with `lnk_ack`=1, while packet-ready is 1 and the endpoint is transmitting, clears packet-ready and the count and flips the toggle. A completion with `lnk_ack`=0 changes nothing.
- R9: With DMA enabled and mode 0, `dma_req` is 1 exactly while the count is below `FIFO_DEPTH`.
- R10: With DMA enabled and mode 1, `dma_req` is 1 exactly while `FIFO_DEPTH` minus the count is at least the maximum packet size.
- R11: A control write that sets mode 0 while DMA enable and mode are both 1 is an ordering violation. This covers clearing enable in the same write or keeping it set. `dma_order_err` pulses for one clock after the write, and the write is still applied.
- R12: A load with the count at `FIFO_DEPTH` leaves the count unchanged and sets `fifo_overrun`. The overrun flag stays set until the packet is flushed by an acknowledge or a forced toggle.
- R13: When a flush (acknowledge or forced toggle) lands in the same clock as other events, the flush is applied first. A load in that clock starts a new packet with count 1. A `cpu_set_ready` in that clock is dropped. An acknowledge and a forced toggle together flip the toggle once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 1 | 1 when the controller acts as host |
| cpu_ctrl_wr | input | 1 | Control byte write strobe |
| cpu_ctrl_wdata | input | 8 | Control byte write value |
| cpu_ctrl_rdata | output | 8 | Control byte read value |
| cpu_maxp_wr | input | 1 | Maximum packet size write strobe |
| cpu_maxp_wdata | input | MAXP_W (11) | Maximum packet size in bytes |
| cpu_load | input | 1 | One byte pushed into the endpoint buffer |
| cpu_set_ready | input | 1 | Software raises packet-ready |
| lnk_done | input | 1 | Link finished a transmission attempt |
| lnk_ack | input | 1 | With `lnk_done`: 1 = acknowledged, 0 = rejected or timed out |
| pkt_ready | output | 1 | Queued packet is handed to the link |
| data_toggle | output | 1 | Current data PID toggle (0 = DATA0) |
| fifo_count | output | CNT_W (11) | Bytes held in the buffer |
| fifo_overrun | output | 1 | A load hit a full buffer |
| dma_req | output | 1 | DMA request |
| dma_order_err | output | 1 | One-clock pulse on an illegal DMA mode/enable ordering |
| iso_active | output | 1 | Endpoint runs isochronous transfers |
| tx_enabled | output | 1 | Endpoint acts in the transmit direction |

## Verification
The key same-cycle collisions are a flush and a load, a flush and a manual ready, and a link acknowledge together with a forced toggle. Directed cycles drive each pair in one clock edge. The bench then checks that the count restarts at 1, that packet-ready stays low, and that the toggle moves by exactly one step. A long random phase keeps loads dense and completions and control writes frequent, so these pairs also arise unprompted. Every clock is judged against a bench model that applies the flush before the other events.

// File: rtl/usb_txep_pkg.sv
package usb_txep_pkg;

  localparam int unsigned CB_AUTO    = 7;
  localparam int unsigned CB_ISO     = 6;
  localparam int unsigned CB_DIR     = 5;
  localparam int unsigned CB_DMAEN   = 4;
  localparam int unsigned CB_FORCE   = 3;
  localparam int unsigned CB_DMAMODE = 2;

  typedef struct packed {
    logic auto_set;
    logic iso;
    logic dir_tx;
    logic dma_en;
    logic dma_mode;
  } ep_ctrl_t;

  // bytes still free in the endpoint buffer
  function automatic logic [31:0] room_left(logic [31:0] fill, logic [31:0] depth);
    return depth - fill;
  endfunction

  // request condition per mode: mode 0 needs one byte, mode 1 a full packet
  function automatic logic dma_wanted(logic mode1, logic [31:0] room, logic [31:0] maxp);
    return mode1 ? (room >= maxp) : (room != 32'd0);
  endfunction

  // mode cleared while enable still set before the write
  function automatic logic order_violation(logic en_old, logic mode_old, logic mode_new);
    return en_old & mode_old & ~mode_new;
  endfunction

  function automatic logic [7:0] pack_ctrl(ep_ctrl_t c, logic host);
    logic [7:0] b;
    b = 8'h00;
    b[CB_AUTO]    = c.auto_set;
    b[CB_ISO]     = c.iso & ~host;
    b[CB_DIR]     = c.dir_tx;
    b[CB_DMAEN]   = c.dma_en;
    b[CB_DMAMODE] = c.dma_mode;
    return b;
  endfunction

endpackage

// File: rtl/txep_ctrl_reg.sv
module txep_ctrl_reg
  import usb_txep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       host_mode,
  output ep_ctrl_t   ctrl,
  output logic [7:0] rdata,
  output logic       force_req,
  output logic       order_err
);

  logic unused_low;
  assign unused_low = ^wdata[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      order_err <= 1'b0;
    end else begin
      order_err <= wr & order_violation(ctrl.dma_en, ctrl.dma_mode, wdata[CB_DMAMODE]);
      if (wr) begin
        ctrl.auto_set <= wdata[CB_AUTO];
        ctrl.iso      <= wdata[CB_ISO];
        ctrl.dir_tx   <= wdata[CB_DIR];
        ctrl.dma_en   <= wdata[CB_DMAEN];
        ctrl.dma_mode <= wdata[CB_DMAMODE];
      end
    end
  end

  assign force_req = wr & wdata[CB_FORCE];
  assign rdata     = pack_ctrl(ctrl, host_mode);

endmodule

// File: rtl/txep_fill.sv
module txep_fill #(
  parameter int unsigned FIFO_DEPTH = 1024,
  parameter int unsigned CNT_W      = 11,
  parameter int unsigned MAXP_W     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              sw_set,
  input  logic              flush,
  input  logic              auto_set,
  input  logic [MAXP_W-1:0] maxp,
  output logic [CNT_W-1:0]  count,
  output logic              ready,
  output logic              overrun,
  output logic              toggle,
  output logic              auto_hit
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(FIFO_DEPTH);

  logic [CNT_W-1:0] base, count_n;
  logic             full_load, ready_n, overrun_n;

  always_comb begin
    base      = flush ? '0 : count;
    full_load = load && (base == FULL);
    count_n   = base;
    if (load && !full_load) count_n = base + CNT_W'(1);
    auto_hit  = load & ~full_load & auto_set & (32'(count_n) == 32'(maxp));
    overrun_n = (flush ? 1'b0 : overrun) | full_load;
    ready_n   = (flush ? 1'b0 : ready) | (sw_set & ~flush) | auto_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      ready   <= 1'b0;
      overrun <= 1'b0;
      toggle  <= 1'b0;
    end else begin
      count   <= count_n;
      ready   <= ready_n;
      overrun <= overrun_n;
      toggle  <= toggle ^ flush;
    end
  end

endmodule

// File: rtl/txep_dma.sv
module txep_dma
  import usb_txep_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 1024,
  parameter int unsigned CNT_W      = 11,
  parameter int unsigned MAXP_W     = 11
) (
  input  logic [CNT_W-1:0]  count,
  input  logic [MAXP_W-1:0] maxp,
  input  logic              en,
  input  logic              mode1,
  input  logic              tx_en,
  output logic              req
);

  logic [31:0] room;

  assign room = room_left(32'(count), 32'(FIFO_DEPTH));
  assign req  = tx_en & en & dma_wanted(mode1, room, 32'(maxp));

endmodule

// File: rtl/usb_tx_ep_ctrl.sv
module usb_tx_ep_ctrl
  import usb_txep_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 1024,
  parameter int unsigned MAXP_LIMIT  = 1024,
  parameter bit          SHARED_FIFO = 1'b1,
  localparam int unsigned MAXP_W     = $clog2(MAXP_LIMIT + 1),
  localparam int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_mode,
  input  logic              cpu_ctrl_wr,
  input  logic [7:0]        cpu_ctrl_wdata,
  output logic [7:0]        cpu_ctrl_rdata,
  input  logic              cpu_maxp_wr,
  input  logic [MAXP_W-1:0] cpu_maxp_wdata,
  input  logic              cpu_load,
  input  logic              cpu_set_ready,
  input  logic              lnk_done,
  input  logic              lnk_ack,
  output logic              pkt_ready,
  output logic              data_toggle,
  output logic [CNT_W-1:0]  fifo_count,
  output logic              fifo_overrun,
  output logic              dma_req,
  output logic              dma_order_err,
  output logic              iso_active,
  output logic              tx_enabled
);

  ep_ctrl_t          ctrl;
  logic              force_req;
  logic [MAXP_W-1:0] maxp_q;
  logic              tx_en;
  logic              ack_evt;
  logic              flush_evt;
  logic              auto_hit;

  txep_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (cpu_ctrl_wr),
    .wdata     (cpu_ctrl_wdata),
    .host_mode (host_mode),
    .ctrl      (ctrl),
    .rdata     (cpu_ctrl_rdata),
    .force_req (force_req),
    .order_err (dma_order_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           maxp_q <= '0;
    else if (cpu_maxp_wr) maxp_q <= cpu_maxp_wdata;
  end

  generate
    if (SHARED_FIFO) begin : g_shared
      assign tx_en = ctrl.dir_tx;
    end else begin : g_dedicated
      assign tx_en = 1'b1;
    end
  endgenerate

  assign ack_evt   = lnk_done & lnk_ack & pkt_ready & tx_en;
  assign flush_evt = force_req | ack_evt;

  txep_fill #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (CNT_W),
    .MAXP_W     (MAXP_W)
  ) u_fill (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cpu_load),
    .sw_set   (cpu_set_ready),
    .flush    (flush_evt),
    .auto_set (ctrl.auto_set),
    .maxp     (maxp_q),
    .count    (fifo_count),
    .ready    (pkt_ready),
    .overrun  (fifo_overrun),
    .toggle   (data_toggle),
    .auto_hit (auto_hit)
  );

  txep_dma #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (CNT_W),
    .MAXP_W     (MAXP_W)
  ) u_dma (
    .count (fifo_count),
    .maxp  (maxp_q),
    .en    (ctrl.dma_en),
    .mode1 (ctrl.dma_mode),
    .tx_en (tx_en),
    .req   (dma_req)
  );

  assign iso_active = ctrl.iso & ~host_mode;
  assign tx_enabled = tx_en;

endmodule

// File: rtl/txep_checker.sv
module txep_checker #(
  parameter int unsigned FIFO_DEPTH = 1024,
  parameter int unsigned CNT_W      = 11,
  parameter int unsigned MAXP_W     = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_mode,
  input logic              cpu_ctrl_wr,
  input logic              wr_mode_bit,
  input logic [7:0]        cpu_ctrl_rdata,
  input logic              cpu_load,
  input logic              cpu_set_ready,
  input logic              pkt_ready,
  input logic              data_toggle,
  input logic [CNT_W-1:0]  fifo_count,
  input logic              fifo_overrun,
  input logic              dma_req,
  input logic              dma_order_err,
  input logic              iso_active,
  input logic              tx_enabled,
  input logic              ack_evt,
  input logic              flush_evt,
  input logic [MAXP_W-1:0] maxp_q
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(FIFO_DEPTH);

  assert_no_manual_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_ready && !cpu_set_ready && !cpu_ctrl_rdata[7]) |=> !pkt_ready);

  assert_iso_host_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_mode |-> (!cpu_ctrl_rdata[6] && !iso_active));

  assert_toggle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_evt |=> $stable(data_toggle));

  assert_toggle_flip_R13: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> (data_toggle != $past(data_toggle)));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && !cpu_load) |=> (!pkt_ready && fifo_count == '0));

  assert_dma_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (tx_enabled && cpu_ctrl_rdata[4]));

  assert_mode1_room_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && cpu_ctrl_rdata[2]) |-> ((32'(FIFO_DEPTH) - 32'(fifo_count)) >= 32'(maxp_q)));

  assert_order_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ctrl_wr && cpu_ctrl_rdata[4] && cpu_ctrl_rdata[2] && !wr_mode_bit) |=> dma_order_err);

  assert_overrun_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_load && fifo_count == FULL && !flush_evt) |=> (fifo_overrun && fifo_count == FULL));

  assert_count_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= FULL);

endmodule

bind usb_tx_ep_ctrl txep_checker #(
  .FIFO_DEPTH (FIFO_DEPTH),
  .CNT_W      (CNT_W),
  .MAXP_W     (MAXP_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_mode      (host_mode),
  .cpu_ctrl_wr    (cpu_ctrl_wr),
  .wr_mode_bit    (cpu_ctrl_wdata[2]),
  .cpu_ctrl_rdata (cpu_ctrl_rdata),
  .cpu_load       (cpu_load),
  .cpu_set_ready  (cpu_set_ready),
  .pkt_ready      (pkt_ready),
  .data_toggle    (data_toggle),
  .fifo_count     (fifo_count),
  .fifo_overrun   (fifo_overrun),
  .dma_req        (dma_req),
  .dma_order_err  (dma_order_err),
  .iso_active     (iso_active),
  .tx_enabled     (tx_enabled),
  .ack_evt        (ack_evt),
  .flush_evt      (flush_evt),
  .maxp_q         (maxp_q)
);

// File: tb/tb_usb_tx_ep_ctrl.sv
`timescale 1ns/1ps
module tb_usb_tx_ep_ctrl;

  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_mode = 1'b0;
  logic        cpu_ctrl_wr = 1'b0;
  logic [7:0]  cpu_ctrl_wdata = 8'h00;
  logic [7:0]  cpu_ctrl_rdata;
  logic        cpu_maxp_wr = 1'b0;
  logic [10:0] cpu_maxp_wdata = '0;
  logic        cpu_load = 1'b0;
  logic        cpu_set_ready = 1'b0;
  logic        lnk_done = 1'b0;
  logic        lnk_ack = 1'b0;
  logic        pkt_ready, data_toggle, fifo_overrun, dma_req, dma_order_err;
  logic        iso_active, tx_enabled;
  logic [6:0]  fifo_count;

  int checks = 0;
  int fails  = 0;

  // bench model state
  logic m_auto, m_iso, m_dir, m_en, m_mode, m_rdy, m_tog, m_ovr, m_oerr;
  int   m_cnt, m_maxp;

  always #10 clk = ~clk;

  usb_tx_ep_ctrl #(.FIFO_DEPTH(DEPTH), .MAXP_LIMIT(1024), .SHARED_FIFO(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
    .cpu_ctrl_wr(cpu_ctrl_wr), .cpu_ctrl_wdata(cpu_ctrl_wdata), .cpu_ctrl_rdata(cpu_ctrl_rdata),
    .cpu_maxp_wr(cpu_maxp_wr), .cpu_maxp_wdata(cpu_maxp_wdata),
    .cpu_load(cpu_load), .cpu_set_ready(cpu_set_ready),
    .lnk_done(lnk_done), .lnk_ack(lnk_ack),
    .pkt_ready(pkt_ready), .data_toggle(data_toggle), .fifo_count(fifo_count),
    .fifo_overrun(fifo_overrun), .dma_req(dma_req), .dma_order_err(dma_order_err),
    .iso_active(iso_active), .tx_enabled(tx_enabled)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rdata();
    return {m_auto, m_iso & ~host_mode, m_dir, m_en, 1'b0, m_mode, 2'b00};
  endfunction

  function automatic logic exp_dma();
    int room;
    room = DEPTH - m_cnt;
    if (!(m_dir && m_en)) return 1'b0;
    return m_mode ? (room >= m_maxp) : (room > 0);
  endfunction

  task automatic compare_all();
    chk("R2 control readback", cpu_ctrl_rdata, exp_rdata());
    chk("R3/R4 packet-ready", pkt_ready, m_rdy);
    chk("R7/R8 toggle", data_toggle, m_tog);
    chk("R12 count", fifo_count, m_cnt);
    chk("R12 overrun", fifo_overrun, m_ovr);
    chk("R9/R10 dma request", dma_req, exp_dma());
    chk("R11 order error", dma_order_err, m_oerr);
    chk("R5 iso active", iso_active, m_iso & ~host_mode);
    chk("R6 tx enabled", tx_enabled, m_dir);
  endtask

  // one clock: drive, predict, step, compare
  task automatic cyc(input logic wr, input logic [7:0] wd, input logic mwr, input int mp,
                     input logic ld, input logic st, input logic dn, input logic ak);
    logic frc, ack, fl, hit, n_rdy, n_ovr;
    int   base, n_cnt;
    cpu_ctrl_wr = wr; cpu_ctrl_wdata = wd; cpu_maxp_wr = mwr; cpu_maxp_wdata = 11'(mp);
    cpu_load = ld; cpu_set_ready = st; lnk_done = dn; lnk_ack = ak;
    frc   = wr & wd[3];
    ack   = dn & ak & m_rdy & m_dir;
    fl    = frc | ack;
    base  = fl ? 0 : m_cnt;
    n_ovr = fl ? 1'b0 : m_ovr;
    n_cnt = base;
    hit   = 1'b0;
    if (ld) begin
      if (base == DEPTH) n_ovr = 1'b1;
      else begin
        n_cnt = base + 1;
        hit   = m_auto && (n_cnt == m_maxp);
      end
    end
    n_rdy = (fl ? 1'b0 : m_rdy) | (st & ~fl) | hit;
    @(posedge clk); #1;
    m_oerr = wr & m_en & m_mode & ~wd[2];
    if (wr) begin
      m_auto = wd[7]; m_iso = wd[6]; m_dir = wd[5]; m_en = wd[4]; m_mode = wd[2];
    end
    if (mwr) m_maxp = mp;
    m_cnt = n_cnt; m_rdy = n_rdy; m_ovr = n_ovr; m_tog = m_tog ^ fl;
    cpu_ctrl_wr = 1'b0; cpu_maxp_wr = 1'b0; cpu_load = 1'b0;
    cpu_set_ready = 1'b0; lnk_done = 1'b0; lnk_ack = 1'b0;
    compare_all();
  endtask

  task automatic idle();           cyc(0, 8'h00, 0, 0, 0, 0, 0, 0); endtask
  task automatic wctrl(input logic [7:0] v); cyc(1, v, 0, 0, 0, 0, 0, 0); endtask
  task automatic wmaxp(input int v); cyc(0, 8'h00, 1, v, 0, 0, 0, 0); endtask
  task automatic load_n(input int n);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 0, 1, 0, 0, 0);
  endtask
  task automatic setrdy();         cyc(0, 8'h00, 0, 0, 0, 1, 0, 0); endtask
  task automatic done(input logic a); cyc(0, 8'h00, 0, 0, 0, 0, 1, a); endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic t0;
    void'($urandom(32'h5eed_0042));
    m_auto = 0; m_iso = 0; m_dir = 0; m_en = 0; m_mode = 0;
    m_rdy = 0; m_tog = 0; m_ovr = 0; m_oerr = 0; m_cnt = 0; m_maxp = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 rdata", cpu_ctrl_rdata, 0);
    chk("R1 ready", pkt_ready, 0);
    chk("R1 count", fifo_count, 0);
    chk("R1 toggle/overrun/dma/err", {data_toggle, fifo_overrun, dma_req, dma_order_err}, 0);

    // R3 auto-ready at exact maximum
    wmaxp(4);
    wctrl(8'hA0);
    chk("R2 layout auto+dir", cpu_ctrl_rdata, 8'hA0);
    load_n(3);
    chk("R3 not yet ready at 3 of 4", pkt_ready, 0);
    load_n(1);
    chk("R3 ready at max size", pkt_ready, 1);
    // R8 acknowledge
    done(1);
    chk("R8 ack clears ready", pkt_ready, 0);
    chk("R8 ack empties", fifo_count, 0);
    chk("R8 ack flips toggle", data_toggle, 1);
    // R4 short packet needs manual set
    load_n(2);
    chk("R4 short packet not ready", pkt_ready, 0);
    setrdy();
    chk("R4 manual set", pkt_ready, 1);
    done(0);
    chk("R8 nak keeps ready", pkt_ready, 1);
    chk("R8 nak keeps count", fifo_count, 2);
    chk("R8 nak keeps toggle", data_toggle, 1);
    done(1);
    // R4 auto-ready off
    wctrl(8'h20);
    load_n(5);
    chk("R4 auto off never ready", pkt_ready, 0);
    // R7 forced toggle
    wctrl(8'h28);
    chk("R7 force flips toggle", data_toggle, 1);
    chk("R7 force empties", fifo_count, 0);
    chk("R2 force bit reads 0", cpu_ctrl_rdata, 8'h20);
    // R5 isochronous qualifier
    wctrl(8'h60);
    chk("R5 iso device readback", cpu_ctrl_rdata, 8'h60);
    chk("R5 iso active device", iso_active, 1);
    host_mode = 1'b1; #1;
    chk("R5 iso host readback", cpu_ctrl_rdata, 8'h20);
    chk("R5 iso inactive host", iso_active, 0);
    host_mode = 1'b0;
    // R6 receive direction on shared buffer
    wctrl(8'h10);
    chk("R6 tx disabled", tx_enabled, 0);
    chk("R6 no dma when rx", dma_req, 0);
    load_n(1); setrdy(); done(1);
    chk("R6 ack ignored ready", pkt_ready, 1);
    chk("R6 ack ignored toggle", data_toggle, 1);
    wctrl(8'h18);
    // R9 / R10 request modes
    wmaxp(40);
    wctrl(8'h30);
    chk("R9 mode0 empty", dma_req, 1);
    load_n(30);
    chk("R9 mode0 room", dma_req, 1);
    wctrl(8'h34);
    chk("R10 mode1 short room", dma_req, 0);
    wctrl(8'h3C);
    chk("R10 mode1 full room", dma_req, 1);
    // R11 ordering
    wctrl(8'h30);
    chk("R11 mode cleared first", dma_order_err, 1);
    chk("R11 write applied", cpu_ctrl_rdata, 8'h30);
    idle();
    chk("R11 pulse one clock", dma_order_err, 0);
    wctrl(8'h34);
    wctrl(8'h20);
    chk("R11 same-write clear", dma_order_err, 1);
    wctrl(8'h34); wctrl(8'h24);
    chk("R11 enable first ok", dma_order_err, 0);
    wctrl(8'h20);
    chk("R11 mode after enable ok", dma_order_err, 0);
    // R12 overrun
    load_n(DEPTH);
    chk("R12 full count", fifo_count, DEPTH);
    chk("R9 mode0 full no req", {1'b0, dma_req}, 0);
    load_n(1);
    chk("R12 overrun set", fifo_overrun, 1);
    chk("R12 count held", fifo_count, DEPTH);
    setrdy(); done(1);
    chk("R12 overrun cleared by ack", fifo_overrun, 0);
    // R13 same-cycle collisions
    load_n(3); setrdy();
    cyc(0, 8'h00, 0, 0, 1, 0, 1, 1);
    chk("R13 ack+load restarts at 1", fifo_count, 1);
    chk("R13 ack+load ready low", pkt_ready, 0);
    cyc(1, 8'h28, 0, 0, 0, 1, 0, 0);
    chk("R13 force beats set", pkt_ready, 0);
    setrdy();
    t0 = data_toggle;
    cyc(1, 8'h28, 0, 0, 0, 0, 1, 1);
    chk("R13 ack+force single flip", data_toggle, !t0);

    // constrained random phase
    for (int i = 0; i < 6000; i++) begin
      logic       wr, mw, ld, st, dn, ak;
      logic [7:0] wd;
      int         mp;
      wr = ($urandom % 16) == 0;
      wd = 8'($urandom);
      if (($urandom % 4) != 0) wd[3] = 1'b0;
      if (($urandom % 4) != 0) wd[5] = 1'b1;
      mw = ($urandom % 64) == 0;
      mp = 1 + ($urandom % DEPTH);
      ld = ($urandom % 3) != 0;
      st = ($urandom % 12) == 0;
      dn = ($urandom % 6) == 0;
      ak = ($urandom % 4) != 0;
      if (($urandom % 200) == 0) host_mode = ~host_mode;
      cyc(wr, wd, mw, mp, ld, st, dn, ak);
    end

    summary();
    $finish;
  end

endmodule